// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block turns a set of active-low external interrupt pins into request flags for a downstream interrupt controller. Each pin first passes through a two-stage synchronizer. A per-channel trigger-type bit then selects one of two modes. In edge mode, a falling edge on the synchronized pin sets a sticky request flag. In level mode, the flag simply follows the inverted pin.

The interrupt controller pulses a per-channel acknowledge when it vectors to that channel's service routine. In edge mode the acknowledge clears the flag. In level mode it has no effect, because the flag keeps tracking the pin. Software reaches the trigger-type bits and the flags through one plain register port: a write-enable with write data, and a read bus that always shows the current register contents.

Top module: `exint_detect`

## Requirements
- R1: After reset, every request flag and every trigger-type bit is 0, so all channels start in level mode with no request pending.
- R2: Each pin passes through two synchronizer flops. A pin change that is set up before rising edge k shows on `irq_req` just after rising edge k+2, and not before.
- R3: With the channel's type bit at 1 (edge mode), a high-to-low transition of the synchronized pin sets the flag. The flag then stays set while the pin is held low or returns high.
- R4: In edge mode, `irq_ack[i]` high at a rising edge clears flag i at that edge.
- R5: With the type bit at 0 (level mode), the flag equals the inverse of the synchronized pin. `irq_ack` has no effect in this mode.
- R6: In edge mode, a falling edge that is detected in the same cycle as an acknowledge leaves the flag set.
- R7: A write (`reg_wr_en` high) loads the type bits from `reg_wr_data[2*NCH-1:NCH]`. In edge mode it also loads flag i from `reg_wr_data[i]`, so a 1 sets the flag and a 0 clears it. A write takes priority over an acknowledge in the same cycle. In level mode the written flag bit is ignored. Whether a channel is in edge or level mode is decided by its type bit as it stood before the write.
- R8: `reg_rd_data` shows the type bits in `[2*NCH-1:NCH]` and the flags in `[NCH-1:0]`, with no added latency.
- R9: A rising edge on a pin never sets an edge-mode flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | NCH | Raw active-low interrupt pins, asynchronous |
| irq_ack | input | NCH | Per-channel acknowledge strobe from the interrupt controller |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 2*NCH | Write data: type bits in the upper half, flags in the lower half |
| reg_rd_data | output | 2*NCH | Read data: type bits in the upper half, flags in the lower half |
| irq_req | output | NCH | Request flags |

## Verification
The bench drives an acknowledge on exactly the edge where a new falling edge is detected. A design that lets the clear win would lose that interrupt. It also counts edges after a pin change, which exposes a missing or extra synchronizer stage as a flag that moves one cycle early or late. It issues a write together with an acknowledge, issues flag writes and acknowledges in level mode, and returns a pin high after its flag was cleared. These catch a design that gives the acknowledge the wrong priority over a write, that latches in level mode, or that also triggers on rising edges. Random pins, acknowledges and writes across both modes are compared against a model computed in the bench.

// File: rtl/exint_pkg.sv
package exint_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;
endpackage

// File: rtl/exint_sync.sv
// Pin synchronizer with one extra delayed copy for falling-edge detection.
module exint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_n};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/exint_chan.sv
// One channel's request flag: sticky in edge mode, follows the pin in level mode.
module exint_chan
  import exint_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e mode,
  input  logic  lvl,
  input  logic  lvl_prev,
  input  logic  ack,
  input  logic  wr_en,
  input  logic  wr_bit,
  output logic  flag
);
  logic flag_q;
  logic flag_d;
  logic fall;

  assign fall = lvl_prev & ~lvl;

  always_comb begin
    if (mode == TRIG_LEVEL) begin
      flag_d = ~lvl;
    end else begin
      flag_d = flag_q;
      if (wr_en)    flag_d = wr_bit;
      else if (ack) flag_d = 1'b0;
      if (fall)     flag_d = 1'b1;   // a new edge outranks a clear
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/exint_detect.sv
module exint_detect
  import exint_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   irq_pin_n,
  input  logic [NCH-1:0]   irq_ack,
  input  logic             reg_wr_en,
  input  logic [2*NCH-1:0] reg_wr_data,
  output logic [2*NCH-1:0] reg_rd_data,
  output logic [NCH-1:0]   irq_req
);
  localparam int RW = 2 * NCH;

  logic [NCH-1:0] trig_q;
  logic [NCH-1:0] lvl_sync;
  logic [NCH-1:0] lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         trig_q <= '0;
    else if (reg_wr_en) trig_q <= reg_wr_data[RW-1:NCH];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    exint_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (irq_pin_n[i]),
      .sync_o (lvl_sync[i]),
      .prev_o (lvl_prev[i])
    );

    exint_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (trig_e'(trig_q[i])),
      .lvl      (lvl_sync[i]),
      .lvl_prev (lvl_prev[i]),
      .ack      (irq_ack[i]),
      .wr_en    (reg_wr_en),
      .wr_bit   (reg_wr_data[i]),
      .flag     (irq_req[i])
    );
  end

  assign reg_rd_data = {trig_q, irq_req};
endmodule

// File: rtl/exint_detect_chk.sv
module exint_detect_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ack,
  input logic           wr_en,
  input logic [NCH-1:0] wr_flags,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] lvl_sync,
  input logic [NCH-1:0] lvl_prev,
  input logic [NCH-1:0] trig
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && lvl_prev[i] && !lvl_sync[i]) |=> req[i]);               // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && ack[i] && !wr_en && !(lvl_prev[i] && !lvl_sync[i])) |=> !req[i]); // R4
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && req[i] && !ack[i] && !wr_en) |=> req[i]);               // R3
    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig[i]) |=> (req[i] == !$past(lvl_sync[i])));                    // R5
    AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && trig[i] && wr_flags[i]) |=> req[i]);                      // R7
  end
endmodule

bind exint_detect exint_detect_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (irq_ack),
  .wr_en    (reg_wr_en),
  .wr_flags (reg_wr_data[NCH-1:0]),
  .req      (irq_req),
  .lvl_sync (lvl_sync),
  .lvl_prev (lvl_prev),
  .trig     (trig_q)
);

// File: tb/sim_exint_detect.sv
`timescale 1ns/1ps
module sim_exint_detect;
  localparam int N = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pins = '1;
  logic [N-1:0]   ack = '0;
  logic           wr = 1'b0;
  logic [2*N-1:0] wd = '0;
  logic [2*N-1:0] rd;
  logic [N-1:0]   req;

  int n_chk = 0;
  int n_bad = 0;

  // requirement model state
  logic [N-1:0] m_s1 = '1, m_s2 = '1, m_prev = '1, m_flag = '0, m_type = '0;

  always #2.5 clk = ~clk;

  exint_detect u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(pins), .irq_ack(ack),
    .reg_wr_en(wr), .reg_wr_data(wd), .reg_rd_data(rd), .irq_req(req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // next flag per the requirements (mode taken before the write)
  function automatic logic exp_flag(logic typ, logic flg, logic s2, logic prv,
                                    logic a, logic w, logic wbit);
    logic nf;
    if (!typ) return !s2;                  // R5
    nf = flg;
    if (w) nf = wbit;                      // R7
    else if (a) nf = 1'b0;                 // R4
    if (prv && !s2) nf = 1'b1;             // R3 / R6
    return nf;
  endfunction

  task automatic model_clk();
    logic [N-1:0] nf;
    for (int i = 0; i < N; i++)
      nf[i] = exp_flag(m_type[i], m_flag[i], m_s2[i], m_prev[i], ack[i], wr, wd[i]);
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pins; m_flag = nf;
    if (wr) m_type = wd[2*N-1:N];
  endtask

  // apply inputs (at a falling edge), clock once, compare at the next falling edge
  task automatic step(input logic [N-1:0] p, input logic [N-1:0] a,
                      input logic w, input logic [2*N-1:0] d);
    pins = p; ack = a; wr = w; wd = d;
    @(posedge clk);
    model_clk();
    @(negedge clk);
    ack = '0; wr = 1'b0;
    for (int i = 0; i < N; i++)
      check(m_type[i] ? "R3" : "R5", int'(req[i]), int'(m_flag[i]));
    check("R8", int'(rd), int'({m_type, m_flag}));
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(req), 0);
    check("R1", int'(rd), 0);

    // R2 latency, level mode
    step(2'b10, 0, 0, 0); check("R2", int'(req[0]), 0);
    step(2'b10, 0, 0, 0); check("R2", int'(req[0]), 0);
    step(2'b10, 0, 0, 0); check("R2", int'(req[0]), 1);
    // R5 ack ignored, R7 flag write ignored in level mode
    step(2'b10, 2'b01, 0, 0); check("R5", int'(req[0]), 1);
    step(2'b10, 0, 1, 4'b0000); check("R7", int'(req[0]), 1);
    repeat (3) step(2'b11, 0, 0, 0);
    check("R5", int'(req[0]), 0);

    // switch both channels to edge mode
    step(2'b11, 0, 1, 4'b1100);
    repeat (3) step(2'b01, 0, 0, 0);
    check("R3", int'(req[1]), 1);
    repeat (4) step(2'b01, 0, 0, 0);
    check("R3", int'(req[1]), 1);
    repeat (4) step(2'b11, 0, 0, 0);
    check("R9", int'(req[1]), 1);
    step(2'b11, 2'b10, 0, 0); check("R4", int'(req[1]), 0);
    repeat (4) step(2'b01, 2'b10, 0, 0);
    repeat (4) step(2'b11, 0, 0, 0);
    check("R9", int'(req[1]), 0);

    // R7 write sets; R6 edge with ack on the same edge
    step(2'b11, 0, 1, 4'b1101); check("R7", int'(req[0]), 1);
    step(2'b10, 0, 0, 0);
    step(2'b10, 0, 0, 0);
    step(2'b10, 2'b01, 0, 0); check("R6", int'(req[0]), 1);
    step(2'b11, 2'b01, 0, 0); check("R4", int'(req[0]), 0);
    // write beats ack; write of 0 clears
    step(2'b11, 2'b01, 1, 4'b1101); check("R7", int'(req[0]), 1);
    step(2'b11, 0, 1, 4'b1100); check("R7", int'(req[0]), 0);

    // random mix across both modes
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] p = pins;
      logic [N-1:0] a = '0;
      logic w;
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(3) == 0) p[i] = ~p[i];
        a[i] = ($urandom_range(5) == 0);
      end
      w = ($urandom_range(15) == 0);
      step(p, a, w, 4'($urandom()));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule